// File: doc/BRIEF.md
# Packet-mode I2C master sequencer

This block turns one 32-bit command word into a complete I2C master transaction. The word can ask for an address phase (start), a write burst, a read burst, a not-acknowledge on the final read, and a stop, in any combination. The sequencer always walks those phases in the same fixed order. It drives a byte-level I2C engine through an operation request channel and a response channel. Write data arrives on a byte stream and read data leaves on a byte stream. The pin-level timing is left to the engine.

A 4-bit bus state code is kept between commands, so a command without a stop leaves the bus owned. The next command then skips its own start. Status flags are set as phases finish and are cleared when the next command is accepted. Each phase removes its own bits from the visible command register once it is done, so software can see how far a transaction has gone.

Back-pressure rules. On the engine request channel an operation transfers in a cycle where `eng_valid` and `eng_ready` are both high. Operation and byte stay stable while `eng_valid` waits. Each accepted operation is answered by exactly one `eng_rsp_valid` pulse, which the sequencer always takes. The write stream transfers on `tx_valid && tx_ready`, and `tx_ready` is raised only while a byte is needed. The read stream holds `rx_valid` and `rx_data` until `rx_ready`.

Top module: `i2c_pkt_seq`

## Requirements
- R1: After reset `busy` is 0, `state_code` is 0x0, `status` is 0 and `cmd_now` is 0.
- R2: A command write is accepted only when `bus_en` and `master_mode` are both high and `busy` is low. Otherwise it changes neither `cmd_now` nor `status`, and it causes no engine operation.
- R3: Command bit 0 requests a start. It is carried out only when `state_code` is 0x0. It sends the address byte `{cmd[30:24], cmd[3]}` and leaves `state_code` at 0x3 when that byte's low bit is 1, and at 0x2 when it is 0. From any other state the start is skipped.
- R4: If the engine reports a NAK for the start, `status` bit 1 and bit 17 are both set.
- R5: Engine operation codes are start=0, send=1, receive=2, nack=3, end=4. Phases run in the order start (bit 0), transmit (bit 1), receive (bit 3), receive-last (bit 4), stop (bit 5). When bit 0 was set in the command, the receive phase first issues a repeated start with the address byte unless `state_code` is 0x3.
- R6: A transmit with bit 8 set pulls bytes from the write stream and sends each one, up to `tx_len` bytes. It stops right after a byte the engine NAKs and then sets `status` bit 0. Without bit 8 no bytes move and bit 0 stays clear. Either way `state_code` becomes 0x9.
- R7: A receive with bit 9 set issues `rx_len` receive operations. It delivers each byte, in order, on the read stream under back-pressure. `state_code` becomes 0xA.
- R8: Receive-last issues one nack operation and sets `status` bit 2.
- R9: `state_code` is 0xB while the end operation is outstanding. After it completes, the code is 0x0 and `status` bit 4 is set.
- R10: Each phase clears its own command bits on completion: bit 0; bits 1 and 8; bits 3 and 9; bit 4; bit 5. When bit 16 is set, the end of the command sets `status` bit 16 and clears bits 30:24 and 16. Without bit 16 those bits stay in `cmd_now`. No bit of `cmd_now` is ever set except by an accepted write.
- R11: `busy` rises in the cycle after an accepted write and stays high until every requested phase is done. An accepted write clears `status`.
- R12: `state_code` persists across commands. A command issued while the code is 0x9 skips its start and runs its remaining phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_en | input | 1 | Bus enabled |
| master_mode | input | 1 | Bus configured as master |
| cmd_wr | input | 1 | Command write strobe |
| cmd_wdata | input | 32 | Command word |
| tx_len | input | LEN_W | Bytes to transmit, captured on accept |
| rx_len | input | LEN_W | Bytes to receive, captured on accept |
| cmd_now | output | 32 | Command register with self-cleared bits |
| busy | output | 1 | Command in progress |
| state_code | output | 4 | Bus state code |
| status | output | 18 | Status flags |
| eng_valid | output | 1 | Engine operation request valid |
| eng_ready | input | 1 | Engine accepts operation |
| eng_op | output | 3 | Engine operation code |
| eng_byte | output | 8 | Byte for start/send |
| eng_rsp_valid | input | 1 | Engine response pulse |
| eng_rsp_nak | input | 1 | Response carried a NAK |
| eng_rsp_data | input | 8 | Received byte |
| tx_valid | input | 1 | Write stream valid |
| tx_ready | output | 1 | Write stream ready |
| tx_data | input | 8 | Write stream byte |
| rx_valid | output | 1 | Read stream valid |
| rx_ready | input | 1 | Read stream ready |
| rx_data | output | 8 | Read stream byte |

## Verification
Two things can meet in one cycle: a new command write and a command that is still running. The bench writes a second, different command a few cycles into a long transmit. Only the first command's operations may reach the engine, and the final `cmd_now` and `status` must match the first command alone. The second overlap is a byte handshake on the write or read stream landing next to an engine acceptance or response while `eng_ready`, `tx_valid` and `rx_ready` follow unrelated stall patterns. The scoreboard checks the order and content of every engine operation and every delivered byte.

// File: rtl/i2c_pkt_pkg.sv
package i2c_pkt_pkg;
  localparam int unsigned CMD_W = 32;
  localparam int unsigned STS_W = 18;

  // command bit positions (decoded by software, kept fixed)
  localparam int unsigned CB_START = 0;
  localparam int unsigned CB_TX    = 1;
  localparam int unsigned CB_RX    = 3;
  localparam int unsigned CB_RXL   = 4;
  localparam int unsigned CB_STOP  = 5;
  localparam int unsigned CB_TXDMA = 8;
  localparam int unsigned CB_RXDMA = 9;
  localparam int unsigned CB_PKT   = 16;
  localparam int unsigned CB_ADDR  = 24;
  localparam int unsigned ADDR_W   = 7;

  // status bit positions
  localparam int unsigned SB_TXACK = 0;
  localparam int unsigned SB_TXNAK = 1;
  localparam int unsigned SB_RXEND = 2;
  localparam int unsigned SB_STOP  = 4;
  localparam int unsigned SB_PKT   = 16;
  localparam int unsigned SB_ERR   = 17;

  typedef enum logic [3:0] {
    SC_IDLE   = 4'h0,
    SC_STARTW = 4'h2,
    SC_STARTR = 4'h3,
    SC_TXD    = 4'h9,
    SC_RXD    = 4'hA,
    SC_STOP   = 4'hB
  } bus_code_e;

  typedef enum logic [2:0] {
    OP_START = 3'd0,
    OP_SEND  = 3'd1,
    OP_RECV  = 3'd2,
    OP_NACK  = 3'd3,
    OP_END   = 3'd4
  } eng_op_e;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic pkt;
    logic rxdma;
    logic txdma;
    logic stop;
    logic rxl;
    logic rx;
    logic tx;
    logic start;
  } cmd_view_t;

  function automatic cmd_view_t view_of(input logic [CMD_W-1:0] c);
    cmd_view_t v;
    v.addr  = c[CB_ADDR +: ADDR_W];
    v.pkt   = c[CB_PKT];
    v.rxdma = c[CB_RXDMA];
    v.txdma = c[CB_TXDMA];
    v.stop  = c[CB_STOP];
    v.rxl   = c[CB_RXL];
    v.rx    = c[CB_RX];
    v.tx    = c[CB_TX];
    v.start = c[CB_START];
    return v;
  endfunction
endpackage

// File: rtl/i2c_pkt_cmd_reg.sv
module i2c_pkt_cmd_reg
  import i2c_pkt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CMD_W-1:0] wdata,
  input  logic [CMD_W-1:0] clr_mask,
  output logic [CMD_W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (wr_en) q <= wdata;
    else            q <= q & ~clr_mask;
  end

  // R10
  no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ((q & ~$past(q)) == '0));
endmodule

// File: rtl/i2c_pkt_phase_fsm.sv
module i2c_pkt_phase_fsm
  import i2c_pkt_pkg::*;
#(
  parameter int LEN_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic             acc_start,
  input  logic [LEN_W-1:0] tx_len,
  input  logic [LEN_W-1:0] rx_len,
  input  cmd_view_t        cv,
  output logic [CMD_W-1:0] clr_mask,
  output logic             busy,
  output logic [3:0]       state_code,
  output logic [STS_W-1:0] status,
  output logic             eng_valid,
  input  logic             eng_ready,
  output logic [2:0]       eng_op,
  output logic [7:0]       eng_byte,
  input  logic             eng_rsp_valid,
  input  logic             eng_rsp_nak,
  input  logic [7:0]       eng_rsp_data,
  input  logic             tx_valid,
  output logic             tx_ready,
  input  logic [7:0]       tx_data,
  output logic             rx_valid,
  input  logic             rx_ready,
  output logic [7:0]       rx_data
);
  typedef enum logic [3:0] {
    PH_IDLE, PH_DISP, PH_START, PH_TXPULL, PH_TXSEND,
    PH_RXRS, PH_RXRECV, PH_RXPUSH, PH_RXL, PH_STOP
  } ph_e;

  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

  ph_e              ph, ph_d;
  logic             iss, iss_d;
  logic             ostart, ostart_d;
  logic [3:0]       code, code_d;
  logic [STS_W-1:0] sts, sts_d;
  logic [LEN_W-1:0] txr, txr_d, rxr, rxr_d;
  logic [7:0]       hold, hold_d;
  logic [7:0]       abyte;
  logic             rsp;

  assign abyte = {cv.addr, cv.rx};
  assign rsp   = eng_rsp_valid && iss;

  // engine request channel
  always_comb begin
    eng_valid = 1'b0;
    eng_op    = OP_START;
    eng_byte  = '0;
    case (ph)
      PH_START:  begin eng_valid = !iss; eng_op = OP_START; eng_byte = abyte; end
      PH_TXSEND: begin eng_valid = !iss; eng_op = OP_SEND;  eng_byte = hold;  end
      PH_RXRS:   begin eng_valid = !iss; eng_op = OP_START; eng_byte = abyte; end
      PH_RXRECV: begin eng_valid = !iss; eng_op = OP_RECV; end
      PH_RXL:    begin eng_valid = !iss; eng_op = OP_NACK; end
      PH_STOP:   begin eng_valid = !iss; eng_op = OP_END;  end
      default: ;
    endcase
  end

  assign tx_ready   = (ph == PH_TXPULL);
  assign rx_valid   = (ph == PH_RXPUSH);
  assign rx_data    = hold;
  assign busy       = (ph != PH_IDLE);
  assign state_code = code;
  assign status     = sts;

  always_comb begin
    ph_d     = ph;
    iss_d    = iss;
    ostart_d = ostart;
    code_d   = code;
    sts_d    = sts;
    txr_d    = txr;
    rxr_d    = rxr;
    hold_d   = hold;
    clr_mask = '0;
    if (eng_valid && eng_ready) iss_d = 1'b1;
    if (rsp)                    iss_d = 1'b0;
    case (ph)
      PH_IDLE: begin
        if (accept) begin
          ph_d     = PH_DISP;
          ostart_d = acc_start;
          txr_d    = tx_len;
          rxr_d    = rx_len;
          sts_d    = '0;
        end
      end
      PH_DISP: begin
        if (cv.start) begin
          if (code == SC_IDLE) ph_d = PH_START;
          else                 clr_mask[CB_START] = 1'b1;
        end else if (cv.tx) begin
          if (cv.txdma && txr != '0) begin
            ph_d = PH_TXPULL;
          end else begin
            if (cv.txdma) sts_d[SB_TXACK] = 1'b1;
            code_d = SC_TXD;
            clr_mask[CB_TX]    = 1'b1;
            clr_mask[CB_TXDMA] = 1'b1;
          end
        end else if (cv.rx) begin
          if (ostart && code != SC_STARTR) begin
            ph_d = PH_RXRS;
          end else if (cv.rxdma && rxr != '0) begin
            ph_d = PH_RXRECV;
          end else begin
            code_d = SC_RXD;
            clr_mask[CB_RX]    = 1'b1;
            clr_mask[CB_RXDMA] = 1'b1;
          end
        end else if (cv.rxl) begin
          ph_d = PH_RXL;
        end else if (cv.stop) begin
          ph_d   = PH_STOP;
          code_d = SC_STOP;
        end else begin
          if (cv.pkt) begin
            sts_d[SB_PKT] = 1'b1;
            clr_mask[CB_PKT] = 1'b1;
            clr_mask[CB_ADDR +: ADDR_W] = '1;
          end
          ph_d = PH_IDLE;
        end
      end
      PH_START: begin
        if (rsp) begin
          if (eng_rsp_nak) begin
            sts_d[SB_TXNAK] = 1'b1;
            sts_d[SB_ERR]   = 1'b1;
          end
          code_d = abyte[0] ? SC_STARTR : SC_STARTW;
          clr_mask[CB_START] = 1'b1;
          ph_d = PH_DISP;
        end
      end
      PH_TXPULL: begin
        if (tx_valid) begin
          hold_d = tx_data;
          ph_d   = PH_TXSEND;
        end
      end
      PH_TXSEND: begin
        if (rsp) begin
          txr_d = txr - ONE;
          if (eng_rsp_nak || txr == ONE) begin
            sts_d[SB_TXACK] = 1'b1;
            code_d = SC_TXD;
            clr_mask[CB_TX]    = 1'b1;
            clr_mask[CB_TXDMA] = 1'b1;
            ph_d = PH_DISP;
          end else begin
            ph_d = PH_TXPULL;
          end
        end
      end
      PH_RXRS: begin
        if (rsp) begin
          code_d = SC_STARTR;
          ph_d   = PH_DISP;
        end
      end
      PH_RXRECV: begin
        if (rsp) begin
          hold_d = eng_rsp_data;
          ph_d   = PH_RXPUSH;
        end
      end
      PH_RXPUSH: begin
        if (rx_ready) begin
          rxr_d = rxr - ONE;
          if (rxr == ONE) begin
            code_d = SC_RXD;
            clr_mask[CB_RX]    = 1'b1;
            clr_mask[CB_RXDMA] = 1'b1;
            ph_d = PH_DISP;
          end else begin
            ph_d = PH_RXRECV;
          end
        end
      end
      PH_RXL: begin
        if (rsp) begin
          sts_d[SB_RXEND] = 1'b1;
          clr_mask[CB_RXL] = 1'b1;
          ph_d = PH_DISP;
        end
      end
      PH_STOP: begin
        if (rsp) begin
          code_d = SC_IDLE;
          sts_d[SB_STOP] = 1'b1;
          clr_mask[CB_STOP] = 1'b1;
          ph_d = PH_DISP;
        end
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph     <= PH_IDLE;
      iss    <= 1'b0;
      ostart <= 1'b0;
      code   <= SC_IDLE;
      sts    <= '0;
      txr    <= '0;
      rxr    <= '0;
      hold   <= '0;
    end else begin
      ph     <= ph_d;
      iss    <= iss_d;
      ostart <= ostart_d;
      code   <= code_d;
      sts    <= sts_d;
      txr    <= txr_d;
      rxr    <= rxr_d;
      hold   <= hold_d;
    end
  end

  // R5
  eng_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_valid && !eng_ready) |=> (eng_valid && $stable(eng_op) && $stable(eng_byte)));
  // R5
  one_chan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({eng_valid, tx_ready, rx_valid}));
  // R7
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));
  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!eng_valid && !tx_ready && !rx_valid));
  // R4
  err_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status[SB_ERR] |-> status[SB_TXNAK]);
  // R9
  stop_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_STOP && rsp) |=> (state_code == SC_IDLE && status[SB_STOP]));
endmodule

// File: rtl/i2c_pkt_seq.sv
module i2c_pkt_seq
  import i2c_pkt_pkg::*;
#(
  parameter int LEN_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_en,
  input  logic             master_mode,
  input  logic             cmd_wr,
  input  logic [31:0]      cmd_wdata,
  input  logic [LEN_W-1:0] tx_len,
  input  logic [LEN_W-1:0] rx_len,
  output logic [31:0]      cmd_now,
  output logic             busy,
  output logic [3:0]       state_code,
  output logic [17:0]      status,
  output logic             eng_valid,
  input  logic             eng_ready,
  output logic [2:0]       eng_op,
  output logic [7:0]       eng_byte,
  input  logic             eng_rsp_valid,
  input  logic             eng_rsp_nak,
  input  logic [7:0]       eng_rsp_data,
  input  logic             tx_valid,
  output logic             tx_ready,
  input  logic [7:0]       tx_data,
  output logic             rx_valid,
  input  logic             rx_ready,
  output logic [7:0]       rx_data
);
  logic             accept;
  logic [CMD_W-1:0] clr_mask;
  cmd_view_t        cv;

  assign accept = cmd_wr && bus_en && master_mode && !busy;
  assign cv     = view_of(cmd_now);

  i2c_pkt_cmd_reg u_cmd (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (accept),
    .wdata    (cmd_wdata),
    .clr_mask (clr_mask),
    .q        (cmd_now)
  );

  i2c_pkt_phase_fsm #(.LEN_W(LEN_W)) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .accept        (accept),
    .acc_start     (cmd_wdata[CB_START]),
    .tx_len        (tx_len),
    .rx_len        (rx_len),
    .cv            (cv),
    .clr_mask      (clr_mask),
    .busy          (busy),
    .state_code    (state_code),
    .status        (status),
    .eng_valid     (eng_valid),
    .eng_ready     (eng_ready),
    .eng_op        (eng_op),
    .eng_byte      (eng_byte),
    .eng_rsp_valid (eng_rsp_valid),
    .eng_rsp_nak   (eng_rsp_nak),
    .eng_rsp_data  (eng_rsp_data),
    .tx_valid      (tx_valid),
    .tx_ready      (tx_ready),
    .tx_data       (tx_data),
    .rx_valid      (rx_valid),
    .rx_ready      (rx_ready),
    .rx_data       (rx_data)
  );

  // R2
  gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !busy && !(bus_en && master_mode)) |=> !busy);
endmodule

// File: tb/i2c_pkt_seq_bench.sv
module i2c_pkt_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LW = 12;

  localparam logic [31:0] C_START = 32'h1,   C_TX  = 32'h2,   C_RX   = 32'h8;
  localparam logic [31:0] C_RXL   = 32'h10,  C_STOP = 32'h20, C_TXD = 32'h100;
  localparam logic [31:0] C_RXD   = 32'h200, C_PKT = 32'h10000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_en = 1'b1, master_mode = 1'b1;
  logic cmd_wr = 1'b0;
  logic [31:0] cmd_wdata = '0;
  logic [LW-1:0] tx_len = '0, rx_len = '0;
  logic [31:0] cmd_now;
  logic busy;
  logic [3:0] state_code;
  logic [17:0] status;
  logic eng_valid, eng_ready = 1'b0;
  logic [2:0] eng_op;
  logic [7:0] eng_byte;
  logic eng_rsp_valid = 1'b0, eng_rsp_nak = 1'b0;
  logic [7:0] eng_rsp_data = '0;
  logic tx_valid = 1'b0, tx_ready;
  logic [7:0] tx_data = '0;
  logic rx_valid, rx_ready = 1'b0;
  logic [7:0] rx_data;

  int chk_n = 0, fail_n = 0;
  bit finished = 0;
  logic [10:0] exp_ops[$];
  logic [7:0]  exp_rx[$];
  int nak_addr = -1, nak_send = -1;
  int send_idx = 0, recv_idx = 0, tx_idx = 0;
  logic [7:0] tx_base = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_pkt_seq #(.LEN_W(LW)) u_i2c_pkt_seq (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .master_mode(master_mode),
    .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata), .tx_len(tx_len), .rx_len(rx_len),
    .cmd_now(cmd_now), .busy(busy), .state_code(state_code), .status(status),
    .eng_valid(eng_valid), .eng_ready(eng_ready), .eng_op(eng_op), .eng_byte(eng_byte),
    .eng_rsp_valid(eng_rsp_valid), .eng_rsp_nak(eng_rsp_nak), .eng_rsp_data(eng_rsp_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    chk_n++;
    if (act !== exp) begin
      fail_n++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic push_op(int op, logic [7:0] b);
    exp_ops.push_back({op[2:0], b});
  endtask

  // engine model and op scoreboard
  initial begin
    int cyc = 0;
    bit pend = 0;
    logic pn = 1'b0;
    logic [7:0] pd = '0;
    logic [10:0] e;
    forever begin
      @(negedge clk);
      cyc++;
      if (eng_rsp_valid) eng_rsp_valid = 1'b0;
      else if (pend) begin
        eng_rsp_valid = 1'b1; eng_rsp_nak = pn; eng_rsp_data = pd; pend = 0;
      end
      eng_ready = (cyc % 3) != 1;
      if (eng_valid && eng_ready) begin
        if (exp_ops.size() == 0) chk("R5 unexpected engine op", {21'd0, eng_op, eng_byte}, 32'hFFFF);
        else begin
          e = exp_ops.pop_front();
          chk("R5 engine op/byte", {21'd0, eng_op, eng_byte}, {21'd0, e});
        end
        if (eng_op == 3'd4) chk("R9 code while end outstanding", {28'd0, state_code}, 32'hB);
        pn = 1'b0; pd = '0;
        if (eng_op == 3'd0) pn = (int'(eng_byte[7:1]) == nak_addr);
        if (eng_op == 3'd1) begin pn = (send_idx == nak_send); send_idx++; end
        if (eng_op == 3'd2) begin pd = 8'hA0 + 8'(recv_idx); recv_idx++; end
        pend = 1;
      end
    end
  end

  // write stream source
  initial begin
    int cyc = 0;
    bit adv = 0;
    forever begin
      @(negedge clk);
      cyc++;
      if (adv) tx_idx++;
      tx_valid = (cyc % 5) != 3;
      tx_data  = tx_base + 8'(tx_idx);
      adv = tx_valid && tx_ready;
    end
  end

  // read stream monitor
  initial begin
    int cyc = 0;
    forever begin
      @(negedge clk);
      cyc++;
      rx_ready = (cyc % 4) != 2;
      if (rx_valid && rx_ready) begin
        if (exp_rx.size() == 0) chk("R7 unexpected read byte", {24'd0, rx_data}, 32'hFFFF);
        else chk("R7 read byte order", {24'd0, rx_data}, {24'd0, exp_rx.pop_front()});
      end
    end
  end

  task automatic issue(logic [31:0] c, int txl, int rxl, logic [7:0] tb);
    @(negedge clk);
    send_idx = 0; recv_idx = 0; tx_idx = 0; tx_base = tb;
    cmd_wdata = c; tx_len = LW'(txl); rx_len = LW'(rxl); cmd_wr = 1'b1;
    @(negedge clk);
    cmd_wr = 1'b0;
  endtask

  task automatic run(logic [31:0] c, int txl, int rxl, logic [7:0] tb);
    issue(c, txl, rxl, tb);
    while (busy) @(negedge clk);
  endtask

  task automatic done_chk(string req, logic [3:0] code, logic [17:0] st, logic [31:0] cq);
    chk({req, " all engine ops seen"}, exp_ops.size(), 0);
    chk({req, " all read bytes seen"}, exp_rx.size(), 0);
    chk({req, " state code"}, {28'd0, state_code}, {28'd0, code});
    chk({req, " status"}, {14'd0, status}, {14'd0, st});
    chk({req, " cmd_now"}, cmd_now, cq);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fail_n++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", chk_n, fail_n);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", {31'd0, busy}, 0);
    chk("R1 code", {28'd0, state_code}, 0);
    chk("R1 status", {14'd0, status}, 0);
    chk("R1 cmd_now", cmd_now, 0);

    // R3 R6 R9 R10: write three bytes with stop
    push_op(0, 8'hA0); push_op(1, 8'h10); push_op(1, 8'h11); push_op(1, 8'h12); push_op(4, 8'h00);
    run((32'h50 << 24) | C_START | C_TX | C_TXD | C_STOP | C_PKT, 3, 0, 8'h10);
    chk("R6 bytes pulled", tx_idx, 3);
    done_chk("R10 write", 4'h0, 18'h10011, 32'h0);

    // R7 R8: read four bytes, nack, stop
    push_op(0, 8'h43); push_op(2, 0); push_op(2, 0); push_op(2, 0); push_op(2, 0);
    push_op(3, 0); push_op(4, 0);
    exp_rx.push_back(8'hA0); exp_rx.push_back(8'hA1); exp_rx.push_back(8'hA2); exp_rx.push_back(8'hA3);
    run((32'h21 << 24) | C_START | C_RX | C_RXD | C_RXL | C_STOP | C_PKT, 0, 4, 8'h00);
    done_chk("R8 read", 4'h0, 18'h10014, 32'h0);

    // R5: write then read with repeated start
    push_op(0, 8'h67); push_op(1, 8'h30); push_op(1, 8'h31); push_op(0, 8'h67);
    push_op(2, 0); push_op(2, 0); push_op(3, 0); push_op(4, 0);
    exp_rx.push_back(8'hA0); exp_rx.push_back(8'hA1);
    run((32'h33 << 24) | C_START | C_TX | C_TXD | C_RX | C_RXD | C_RXL | C_STOP | C_PKT, 2, 2, 8'h30);
    done_chk("R5 repeated start", 4'h0, 18'h10015, 32'h0);

    // R4: address NAK
    nak_addr = 'h12;
    push_op(0, 8'h24); push_op(1, 8'h55); push_op(4, 0);
    run((32'h12 << 24) | C_START | C_TX | C_TXD | C_STOP | C_PKT, 1, 0, 8'h55);
    done_chk("R4 address nak", 4'h0, 18'h30013, 32'h0);
    nak_addr = -1;

    // R6 R11: data NAK ends the burst early; status cleared on accept
    nak_send = 1;
    push_op(0, 8'h80); push_op(1, 8'h70); push_op(1, 8'h71); push_op(4, 0);
    run((32'h40 << 24) | C_START | C_TX | C_TXD | C_STOP | C_PKT, 4, 0, 8'h70);
    chk("R6 bytes pulled before nak stop", tx_idx, 2);
    done_chk("R6 data nak", 4'h0, 18'h10011, 32'h0);
    nak_send = -1;

    // R10 R12: no stop, no packet mode
    push_op(0, 8'h2A); push_op(1, 8'h60);
    run((32'h15 << 24) | C_START | C_TX | C_TXD, 1, 0, 8'h60);
    done_chk("R12 bus kept", 4'h9, 18'h00001, 32'h15000000);

    // R12: start skipped while code is 0x9
    push_op(1, 8'h61); push_op(4, 0);
    run((32'h15 << 24) | C_START | C_TX | C_TXD | C_STOP | C_PKT, 1, 0, 8'h61);
    done_chk("R12 start skipped", 4'h0, 18'h10011, 32'h0);

    // R6: transmit without the data-move bit
    push_op(0, 8'h10); push_op(4, 0);
    run((32'h08 << 24) | C_START | C_TX | C_STOP | C_PKT, 2, 0, 8'h00);
    chk("R6 no bytes without bit 8", tx_idx, 0);
    done_chk("R6 no data move", 4'h0, 18'h10010, 32'h0);

    // R2: ignored when bus disabled, then when not master
    bus_en = 1'b0;
    issue((32'h7F << 24) | C_START | C_STOP | C_PKT, 0, 0, 8'h00);
    chk("R2 bus disabled busy", {31'd0, busy}, 0);
    @(negedge clk);
    chk("R2 bus disabled cmd_now", cmd_now, 0);
    chk("R2 bus disabled status kept", {14'd0, status}, 32'h10010);
    bus_en = 1'b1; master_mode = 1'b0;
    issue((32'h7F << 24) | C_START | C_STOP | C_PKT, 0, 0, 8'h00);
    chk("R2 not master busy", {31'd0, busy}, 0);
    @(negedge clk);
    chk("R2 not master cmd_now", cmd_now, 0);
    master_mode = 1'b1;

    // R2 R11: a write during a running command is ignored
    push_op(0, 8'hB4); push_op(1, 8'h20); push_op(1, 8'h21); push_op(1, 8'h22); push_op(4, 0);
    issue((32'h5A << 24) | C_START | C_TX | C_TXD | C_STOP | C_PKT, 3, 0, 8'h20);
    repeat (3) @(negedge clk);
    chk("R11 busy mid command", {31'd0, busy}, 1);
    cmd_wdata = (32'h7F << 24) | C_START | C_RX | C_RXL; cmd_wr = 1'b1;
    @(negedge clk);
    cmd_wr = 1'b0;
    while (busy) @(negedge clk);
    done_chk("R11 overlap ignored", 4'h0, 18'h10011, 32'h0);

    repeat (5) @(negedge clk);
    chk("R5 no stray engine ops", exp_ops.size(), 0);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", chk_n, fail_n);
    $finish;
  end
endmodule